// File: doc/BRIEF.md
# Waveform Timer Channel

This block is a single timer channel that generates waveforms. A counter advances on a counting tick that another block supplies. It compares its value with three programmable compare values, A, B and C, and drives two waveform outputs. The first output reacts to compare A and the second to compare B. Both outputs also react to compare C, to a selectable external event and to a software trigger. Each output has a 2-bit action field for each of these four event kinds. The action is keep, set, clear or flip.

Four counting shapes are available. Two of them use compare C as the top of the count, either by wrapping to zero or by turning the count downward. A compare-C match can stop the counter or disable it. A trigger, from software or from the external event, restarts the count at zero. A small register port, with word addresses, holds the configuration, the sticky event flags and an interrupt mask. It also returns the live count and the state of both outputs.

Top module: `wavegen_chan`

## Requirements
- R1: After reset the count is 0, both outputs are 0, the clock is disabled, and the status flags and the interrupt mask are 0. The register word addresses are: 0 control, 1 mode, 2/3/4 compare A/B/C, 5 count, 6 status, 7 interrupt enable, 8 interrupt disable, 9 interrupt mask.
- R2: The control word is write-only. In it, bit 0 enables the counter clock, bit 1 disables it and bit 2 issues a software trigger. If bits 0 and 1 are written together, disable wins. Status bit 16 reads 1 while the clock is enabled.
- R3: The counter advances only in a cycle where `cnt_tick` is 1, mode bit 15 is 1, the clock is enabled and the counter is not stopped. In any other cycle it holds its value.
- R4: The counting shape is set by mode bits 14:13. Shape 0 counts up and wraps from all-ones to 0. Shape 2 counts up and returns to 0 on the tick that finds the count equal to compare C.
- R5: Shape 1 counts up to all-ones and then down to 0. Shape 3 counts up to compare C and then down to 0. On the way down, a tick at 0 turns the count upward again to 1. Status bit 0 (overflow) is set when an upward count wraps or turns at all-ones.
- R6: A compare match occurs on a counting tick whose current count equals a compare value. Matches set status bits 2 (A), 3 (B) and 4 (C).
- R7: Action codes are 0 keep, 1 set, 2 clear and 3 flip. The first output takes its actions from mode bits 17:16 (compare A), 19:18 (compare C), 21:20 (external event) and 23:22 (software trigger). The second output uses bits 25:24 (compare B), 27:26, 29:28 and 31:30 in the same order. An output changes only at the clock edge of its event.
- R8: When several events with a non-keep action hit one output in the same cycle, the software trigger wins over the external event. The external event wins over compare C, and compare C wins over compare A or B.
- R9: Mode bits 11:10 select the external event source: 0 `evt_pin`, 1 to 3 `aux_in[0]` to `aux_in[2]`. Mode bits 9:8 select the active edge: 0 none, 1 rising, 2 falling, 3 both. When mode bit 12 is 1, the event also acts as a trigger and sets status bit 7.
- R10: A trigger resets the count to 0 on the first counting tick at or after it, and that tick sets the direction to up.
- R11: With mode bit 6 set, a compare-C match stops the counter. A trigger or a clock-enable write restarts it. With mode bit 7 set, a compare-C match disables the clock, and only a clock-enable write restores it.
- R12: Reading the status word returns the flags and clears them at that edge, unless a new event sets them again in the same cycle. Status bits 17 and 18 mirror the first and second outputs.
- R13: Writing 1s to the interrupt-enable word sets those mask bits, and writing 1s to the interrupt-disable word clears them. The mask word is read-only. `irq` is the OR of the status flags ANDed with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status flags on a status read) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cnt_tick | input | 1 | Counting clock enable from the clock selector |
| evt_pin | input | 1 | External event source 0 |
| aux_in | input | 3 | External event sources 1 to 3 |
| wave_a | output | 1 | First waveform output |
| wave_b | output | 1 | Second waveform output |
| irq | output | 1 | Interrupt request |

## Verification
The counter is driven in all three shapes that fit in a short run, with the same compare values each time. Because the compare values are shared, the outputs seen after each run show whether compare C wraps, reverses or is ignored, and show that a match is seen again on the way down. Same-cycle conflicts between a software trigger and compare C, and rising versus falling edges on two different event sources, tell the priority order and the edge selection apart. Runs that stop the counter and runs that disable it, each followed by a trigger and then by a clock-enable write, tell the two compare-C halts apart. A full sweep in shape 1 checks the overflow flag, its interrupt and clear-on-read.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;
  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int NFLAG = 8;

  typedef enum logic [AW-1:0] {
    A_CTRL  = 4'd0,
    A_MODE  = 4'd1,
    A_CMPA  = 4'd2,
    A_CMPB  = 4'd3,
    A_CMPC  = 4'd4,
    A_COUNT = 4'd5,
    A_STAT  = 4'd6,
    A_IEN   = 4'd7,
    A_IDIS  = 4'd8,
    A_IMASK = 4'd9
  } reg_addr_e;

  typedef enum logic [1:0] {ACT_KEEP, ACT_SET, ACT_CLR, ACT_FLIP} act_e;

  // mode word field positions
  localparam int MB_STOP  = 6;
  localparam int MB_DIS   = 7;
  localparam int MB_EDGE  = 8;
  localparam int MB_SRC   = 10;
  localparam int MB_ETRG  = 12;
  localparam int MB_SHAPE = 13;
  localparam int MB_WAVE  = 15;
  localparam int MB_ACT   = 16;
  localparam int ACT_SPAN = 8;

  // status flag positions
  localparam int FL_OVF  = 0;
  localparam int FL_CA   = 2;
  localparam int FL_CB   = 3;
  localparam int FL_CC   = 4;
  localparam int FL_ETRG = 7;
  localparam int ST_CLK  = 16;
  localparam int ST_WA   = 17;
  localparam int ST_WB   = 18;
endpackage

// File: rtl/wavegen_regs.sv
module wavegen_regs
  import wavegen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NFLAG-1:0] flag_set,
  input  logic             clk_on,
  input  logic             wave_a,
  input  logic             wave_b,
  input  logic [CW-1:0]    count,
  output logic [DW-1:6]    mode_cfg,
  output logic [CW-1:0]    cmp_a,
  output logic [CW-1:0]    cmp_b,
  output logic [CW-1:0]    cmp_c,
  output logic             go_en,
  output logic             go_dis,
  output logic             go_trig,
  output logic             irq
);
  logic [DW-1:0]    mode_q;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] mask;
  logic             wr_ctrl;
  logic             rd_stat;

  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign rd_stat  = bus_rd && (bus_addr == A_STAT);
  assign go_en    = wr_ctrl & bus_wdata[0];
  assign go_dis   = wr_ctrl & bus_wdata[1];
  assign go_trig  = wr_ctrl & bus_wdata[2];
  assign mode_cfg = mode_q[DW-1:6];
  assign irq      = |(flags & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmp_a  <= '0;
      cmp_b  <= '0;
      cmp_c  <= '0;
      mask   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE: mode_q <= bus_wdata;
        A_CMPA: cmp_a  <= bus_wdata[CW-1:0];
        A_CMPB: cmp_b  <= bus_wdata[CW-1:0];
        A_CMPC: cmp_c  <= bus_wdata[CW-1:0];
        A_IEN:  mask   <= mask | bus_wdata[NFLAG-1:0];
        A_IDIS: mask   <= mask & ~bus_wdata[NFLAG-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flags <= '0;
    else if (rd_stat) flags <= flag_set;
    else              flags <= flags | flag_set;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_CMPA:  bus_rdata[CW-1:0] = cmp_a;
      A_CMPB:  bus_rdata[CW-1:0] = cmp_b;
      A_CMPC:  bus_rdata[CW-1:0] = cmp_c;
      A_COUNT: bus_rdata[CW-1:0] = count;
      A_STAT: begin
        bus_rdata[NFLAG-1:0] = flags;
        bus_rdata[ST_CLK]    = clk_on;
        bus_rdata[ST_WA]     = wave_a;
        bus_rdata[ST_WB]     = wave_b;
      end
      A_IMASK: bus_rdata[NFLAG-1:0] = mask;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wavegen_counter.sv
module wavegen_counter
  import wavegen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wave_on,
  input  logic [1:0]    shape,
  input  logic          stop_on_c,
  input  logic          dis_on_c,
  input  logic          go_en,
  input  logic          go_dis,
  input  logic          trig,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic [CW-1:0] cmp_c,
  output logic [CW-1:0] count,
  output logic          clk_on,
  output logic          halted,
  output logic          hit_a,
  output logic          hit_b,
  output logic          hit_c,
  output logic          ovf
);
  localparam logic [CW-1:0] TOP = '1;

  logic          dir_dn, pend, run, kick, updn, use_c, at_c;
  logic [CW-1:0] nxt;
  logic          nxt_dn;

  assign run   = tick & wave_on & clk_on & ~halted;
  assign kick  = trig | pend;
  assign updn  = shape[0];
  assign use_c = shape[1];
  assign at_c  = use_c && (count == cmp_c);
  assign hit_a = run && (count == cmp_a);
  assign hit_b = run && (count == cmp_b);
  assign hit_c = run && (count == cmp_c);

  always_comb begin
    nxt    = count;
    nxt_dn = dir_dn;
    ovf    = 1'b0;
    if (run) begin
      if (kick) begin
        nxt    = '0;
        nxt_dn = 1'b0;
      end else if (!updn) begin
        if (at_c) nxt = '0;
        else begin
          nxt = count + CW'(1);
          ovf = (count == TOP);
        end
      end else if (!dir_dn) begin
        if (at_c || count == TOP) begin
          nxt    = count - CW'(1);
          nxt_dn = 1'b1;
          ovf    = (count == TOP);
        end else nxt = count + CW'(1);
      end else if (count == '0) begin
        nxt    = CW'(1);
        nxt_dn = 1'b0;
      end else nxt = count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      dir_dn <= 1'b0;
      pend   <= 1'b0;
      clk_on <= 1'b0;
      halted <= 1'b0;
    end else begin
      count  <= nxt;
      dir_dn <= nxt_dn;
      if (run)       pend <= 1'b0;
      else if (trig) pend <= 1'b1;
      if (go_dis)                clk_on <= 1'b0;
      else if (go_en)            clk_on <= 1'b1;
      else if (hit_c && dis_on_c) clk_on <= 1'b0;
      if (go_en || trig)          halted <= 1'b0;
      else if (hit_c && stop_on_c) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/wavegen_pin.sv
module wavegen_pin
  import wavegen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] evt,   // 0 own compare, 1 compare C, 2 external, 3 software
  input  logic [7:0] acts,  // 2-bit action per event, same order
  output logic       q
);
  act_e sel;

  always_comb begin
    sel = ACT_KEEP;
    for (int k = 0; k < 4; k++) begin
      if (evt[k] && acts[2*k +: 2] != 2'd0) sel = act_e'(acts[2*k +: 2]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else begin
      case (sel)
        ACT_SET:  q <= 1'b1;
        ACT_CLR:  q <= 1'b0;
        ACT_FLIP: q <= ~q;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/wavegen_chan.sv
module wavegen_chan
  import wavegen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [3:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          cnt_tick,
  input  logic          evt_pin,
  input  logic [2:0]    aux_in,
  output logic          wave_a,
  output logic          wave_b,
  output logic          irq
);
  logic [DW-1:6]    mode_cfg;
  logic [CW-1:0]    cmp_a, cmp_b, cmp_c, count;
  logic             go_en, go_dis, go_trig;
  logic             clk_on, halted, hit_a, hit_b, hit_c, ovf;
  logic             wave_on, ext_evt, ext_trig, trig;
  logic [3:0]       raw, raw_q;
  logic             cur, old;
  logic [1:0]       edge_sel, src_sel;
  logic [NFLAG-1:0] flag_set;
  logic [1:0]       pin_q;

  assign wave_on  = mode_cfg[MB_WAVE];
  assign edge_sel = mode_cfg[MB_EDGE +: 2];
  assign src_sel  = mode_cfg[MB_SRC +: 2];
  assign raw      = {aux_in, evt_pin};

  always_ff @(posedge clk) raw_q <= raw;

  assign cur      = raw[src_sel];
  assign old      = raw_q[src_sel];
  assign ext_evt  = wave_on & ((edge_sel[0] & cur & ~old) | (edge_sel[1] & ~cur & old));
  assign ext_trig = ext_evt & mode_cfg[MB_ETRG];
  assign trig     = go_trig | ext_trig;

  always_comb begin
    flag_set          = '0;
    flag_set[FL_OVF]  = ovf;
    flag_set[FL_CA]   = hit_a;
    flag_set[FL_CB]   = hit_b;
    flag_set[FL_CC]   = hit_c;
    flag_set[FL_ETRG] = ext_trig;
  end

  wavegen_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_set(flag_set), .clk_on(clk_on), .wave_a(wave_a), .wave_b(wave_b),
    .count(count), .mode_cfg(mode_cfg), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cmp_c(cmp_c), .go_en(go_en), .go_dis(go_dis), .go_trig(go_trig), .irq(irq)
  );

  wavegen_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .wave_on(wave_on),
    .shape(mode_cfg[MB_SHAPE +: 2]), .stop_on_c(mode_cfg[MB_STOP]),
    .dis_on_c(mode_cfg[MB_DIS]), .go_en(go_en), .go_dis(go_dis), .trig(trig),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .count(count),
    .clk_on(clk_on), .halted(halted), .hit_a(hit_a), .hit_b(hit_b),
    .hit_c(hit_c), .ovf(ovf)
  );

  for (genvar i = 0; i < 2; i++) begin : g_pin
    wavegen_pin u_pin (
      .clk(clk), .rst_n(rst_n),
      .evt({go_trig & wave_on, ext_evt, hit_c, (i == 0) ? hit_a : hit_b}),
      .acts(mode_cfg[MB_ACT + ACT_SPAN*i +: ACT_SPAN]),
      .q(pin_q[i])
    );
  end

  assign wave_a = pin_q[0];
  assign wave_b = pin_q[1];
endmodule

// File: rtl/wavegen_chan_chk.sv
module wavegen_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        cnt_tick,
  input logic        evt_pin,
  input logic [2:0]  aux_in,
  input logic        wave_a,
  input logic        wave_b,
  input logic        irq,
  input logic [15:0] count,
  input logic        clk_on,
  input logic        halted,
  input logic        wave_on
);
  AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd0 && bus_wdata[1]) |=> !clk_on); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(count)); // R3

  AST_OUT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !bus_wr && $stable(evt_pin) && $stable(aux_in))
      |=> ($stable(wave_a) && $stable(wave_b))); // R7

  AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd0 && bus_wdata[2] && cnt_tick && clk_on && !halted && wave_on)
      |=> (count == 16'd0)); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd8 && bus_wdata[7:0] == 8'hFF) |=> !irq); // R13
endmodule

bind wavegen_chan wavegen_chan_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt_tick(cnt_tick), .evt_pin(evt_pin),
  .aux_in(aux_in), .wave_a(wave_a), .wave_b(wave_b), .irq(irq),
  .count(count), .clk_on(clk_on), .halted(halted), .wave_on(wave_on)
);

// File: tb/test_wavegen_chan.sv
`timescale 1ns/1ps
module test_wavegen_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cnt_tick = 1'b0, evt_pin = 1'b0;
  logic [2:0]  aux_in = '0;
  logic        wave_a, wave_b, irq;

  always #4 clk = ~clk;

  wavegen_chan i_wavegen_chan (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_tick(cnt_tick), .evt_pin(evt_pin), .aux_in(aux_in),
    .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
  );

  localparam logic [3:0] CTRL = 4'd0, MODE = 4'd1, CMPA = 4'd2, CMPB = 4'd3,
    CMPC = 4'd4, COUNT = 4'd5, STAT = 4'd6, IEN = 4'd7, IDIS = 4'd8, IMASK = 4'd9;

  typedef struct {
    bit          pin;
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;

  item_t q[$];
  logic  probe = 1'b0;
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;

  // monitor: pops expected items mid-cycle and compares
  always @(negedge clk) begin
    item_t       it;
    logic [31:0] act;
    if (probe && q.size() > 0) begin
      it  = q.pop_front();
      act = it.pin ? {29'b0, irq, wave_b, wave_a} : bus_rdata;
      n_chk++;
      if ((act & it.mask) != (it.exp & it.mask)) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, act & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_drop(input logic [3:0] a);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    cnt_tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 cnt_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_reg(input logic [3:0] a, input logic [31:0] e,
                         input logic [31:0] m, input string tag);
    q.push_back('{1'b0, e, m, tag});
    bus_rd = 1'b1; bus_addr = a; probe = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0; probe = 1'b0;
  endtask

  // pin encoding: bit0 wave_a, bit1 wave_b, bit2 irq
  task automatic chk_pin(input logic [2:0] e, input logic [2:0] m, input string tag);
    q.push_back('{1'b1, {29'b0, e}, {29'b0, m}, tag});
    probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic trig_tick();
    bus_wr = 1'b1; bus_addr = CTRL; bus_wdata = 32'h4; cnt_tick = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; cnt_tick = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_reg(COUNT, 32'h0, 32'hFFFF_FFFF, "R1 count");
    chk_reg(STAT,  32'h0, 32'hFFFF_FFFF, "R1 status");
    chk_reg(IMASK, 32'h0, 32'hFFFF_FFFF, "R1 mask");
    chk_pin(3'b000, 3'b111, "R1 pins");

    // shape 0, A set on A / clear on C, B flips on B
    wr(CMPA, 3); wr(CMPB, 4); wr(CMPC, 6);
    wr(MODE, 32'h0309_8000);
    wr(CTRL, 32'h1);
    ticks(4);
    chk_reg(COUNT, 32'd4, 32'hFFFF, "R3 count after 4 ticks");
    chk_pin(3'b001, 3'b011, "R7 compare A set");
    ticks(1);
    chk_pin(3'b011, 3'b011, "R6 compare B flip");
    ticks(2);
    chk_reg(COUNT, 32'd7, 32'hFFFF, "R4 shape 0 passes C");
    chk_pin(3'b010, 3'b011, "R7 compare C clear");
    chk_reg(STAT, 32'h0005_001C, 32'hFFFF_FFFF, "R12 status flags and mirrors");
    chk_reg(STAT, 32'h0005_0000, 32'hFFFF_FFFF, "R12 flags cleared by read");

    // shape 2 wraps at C
    wr(MODE, 32'h0309_C000);
    wr(CTRL, 32'h4);
    ticks(1);
    chk_reg(COUNT, 32'd0, 32'hFFFF, "R10 trigger zeroes count");
    ticks(4);
    chk_pin(3'b011, 3'b011, "R6 shape 2 compare A");
    ticks(3);
    chk_reg(COUNT, 32'd0, 32'hFFFF, "R4 shape 2 wraps at C");
    chk_pin(3'b000, 3'b011, "R7 shape 2 outputs");

    // shape 3 reverses at C
    wr(MODE, 32'h0309_E000);
    ticks(6);
    ticks(1);
    ticks(2);
    chk_reg(COUNT, 32'd3, 32'hFFFF, "R5 shape 3 reverses at C");
    chk_pin(3'b000, 3'b011, "R5 shape 3 compare B on way down");
    ticks(1);
    chk_pin(3'b001, 3'b001, "R5 shape 3 compare A on way down");
    ticks(3);
    chk_reg(COUNT, 32'd1, 32'hFFFF, "R5 turns up at zero");

    // priority: C set vs software clear in one cycle
    wr(MODE, 32'h0384_8000);
    ticks(5);
    trig_tick();
    chk_pin(3'b010, 3'b011, "R8 software beats compare C");
    chk_reg(COUNT, 32'd0, 32'hFFFF, "R10 trigger on same tick");

    // external event from aux_in[0], rising, acting as trigger
    wr(MODE, 32'h0030_9500);
    rd_drop(STAT);
    ticks(3);
    aux_in[0] = 1'b1; idle(1);
    chk_pin(3'b001, 3'b001, "R9 rising edge flips output");
    aux_in[0] = 1'b0; idle(1);
    chk_pin(3'b001, 3'b001, "R9 falling edge ignored");
    chk_reg(STAT, 32'h80, 32'h80, "R9 external trigger flag");
    ticks(1);
    chk_reg(COUNT, 32'd0, 32'hFFFF, "R9 external trigger zeroes count");
    wr(MODE, 32'h0030_9200);
    evt_pin = 1'b1; idle(1);
    chk_pin(3'b001, 3'b001, "R9 rising ignored on falling select");
    evt_pin = 1'b0; idle(1);
    chk_pin(3'b000, 3'b001, "R9 falling edge on evt_pin");

    // disable wins over enable
    wr(CTRL, 32'h3);
    chk_reg(STAT, 32'h0, 32'h1_0000, "R2 disable wins");
    wr(CTRL, 32'h1);
    chk_reg(STAT, 32'h1_0000, 32'h1_0000, "R2 clock enabled");

    // stop on C
    wr(MODE, 32'h0000_8040);
    wr(CTRL, 32'h4);
    ticks(1); ticks(7); ticks(3);
    chk_reg(COUNT, 32'd7, 32'hFFFF, "R11 stopped at C");
    chk_reg(STAT, 32'h1_0000, 32'h1_0000, "R11 stop keeps clock enabled");
    wr(CTRL, 32'h4);
    ticks(2);
    chk_reg(COUNT, 32'd1, 32'hFFFF, "R11 trigger restarts stopped counter");

    // disable on C
    wr(MODE, 32'h0000_8080);
    wr(CTRL, 32'h4);
    ticks(1); ticks(7);
    chk_reg(STAT, 32'h0, 32'h1_0000, "R11 C disables clock");
    wr(CTRL, 32'h4);
    ticks(2);
    chk_reg(COUNT, 32'd7, 32'hFFFF, "R11 trigger cannot restart disabled");
    wr(CTRL, 32'h1);
    ticks(1);
    chk_reg(COUNT, 32'd0, 32'hFFFF, "R10 pending trigger after enable");

    // shape 1 sweep, overflow interrupt
    wr(IEN, 32'h1);
    chk_reg(IMASK, 32'h1, 32'hFF, "R13 enable sets mask");
    rd_drop(STAT);
    chk_pin(3'b000, 3'b100, "R13 no irq without flag");
    wr(MODE, 32'h0000_A000);
    wr(CTRL, 32'h4);
    ticks(1);
    ticks(65535);
    chk_reg(COUNT, 32'hFFFF, 32'hFFFF, "R5 shape 1 reaches top");
    chk_pin(3'b000, 3'b100, "R13 masked compare flags");
    ticks(1);
    chk_reg(COUNT, 32'hFFFE, 32'hFFFF, "R5 shape 1 turns at top");
    chk_pin(3'b100, 3'b100, "R13 overflow raises irq");
    chk_reg(STAT, 32'h1, 32'h1, "R5 overflow flag");
    chk_pin(3'b000, 3'b100, "R12 read clears irq");
    wr(IDIS, 32'hFF);
    chk_reg(IMASK, 32'h0, 32'hFF, "R13 disable clears mask");

    // waveform bit cleared: no counting
    wr(MODE, 32'h0000_2000);
    ticks(3);
    chk_reg(COUNT, 32'hFFFE, 32'hFFFF, "R3 no count without mode bit 15");

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule